// File: doc/BRIEF.md
# Event-Driven Dual-Issue Instruction Front End

This block sits at the entry of a processing core. Packets come in from the on-chip network or from a system bus. Each one is turned into an instruction, stored in a short queue and handed to the lanes of processing elements. At most two instructions leave the queue in one cycle. Each instruction carries its own mode. In SIMD mode it occupies every lane. In SISD mode it occupies the one lane selected by the low bits of its local offset. When nothing is queued, no lane is busy and no packet is offered, the block drops the clock-enable it gives to the rest of the core, so the core sleeps until the next packet.

Work that cannot change any result is removed on entry. A packet whose operand or coefficient is zero is accepted and then discarded, and so is a packet addressed to another node. The 32-bit target address is split into a 6-bit node field and a 26-bit local offset. Only the offset travels with the issued instruction.

Top module: `fe_event_front`

## Requirements
- R1: After reset the queue is empty, neither issue slot is valid, `clk_en` is 0, and both ready outputs are 1.
- R2: A packet is laid out as bit 64 = mode (1 = SIMD), bits 63:58 = node field, bits 57:32 = local offset, bits 31:16 = coefficient, bits 15:0 = operand. A packet whose node field differs from `NODE_ID` is consumed and never issued.
- R3: A packet whose operand or coefficient is zero is consumed and never issued.
- R4: The queue holds 4 instructions. While it is full, both ready outputs are 0 and an offered packet is not taken.
- R5: A network packet has priority. `bus_ready` is 0 in any cycle in which `net_valid` is 1, and when both sources are offered the network packet is queued first.
- R6: Slot 0 shows the oldest queued instruction and is valid exactly when that instruction's lanes are all free in `lane_busy`. Issue is in order: slot 1 is never valid without slot 0, and a queued instruction that is blocked stays at the head.
- R7: Slot 1 shows the second-oldest instruction in the same cycle only when its lanes are free and do not overlap the lanes of slot 0. Otherwise it waits and issues from slot 0 in a later cycle.
- R8: The lane mask of a SIMD instruction is all ones. The lane mask of a SISD instruction is one-hot at the lane given by the two low offset bits.
- R9: `clk_en` is 1 while a packet is offered, an instruction is queued or any lane is busy. It stays 1 for one further cycle after all of these are idle and is 0 after that.
- R10: An issued instruction carries the 26-bit local offset, the coefficient and the operand of its packet, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset |
| net_valid | input | 1 | Network packet offered |
| net_pkt | input | 65 | Network packet |
| net_ready | output | 1 | Network packet accepted this cycle |
| bus_valid | input | 1 | Bus packet offered |
| bus_pkt | input | 65 | Bus packet |
| bus_ready | output | 1 | Bus packet accepted this cycle |
| lane_busy | input | 4 | Lanes still occupied downstream |
| iss0_valid | output | 1 | Slot 0 issues this cycle |
| iss0_simd | output | 1 | Slot 0 mode, 1 = SIMD |
| iss0_mask | output | 4 | Slot 0 lane mask |
| iss0_off | output | 26 | Slot 0 local offset |
| iss0_coef | output | 16 | Slot 0 coefficient |
| iss0_data | output | 16 | Slot 0 operand |
| iss1_valid | output | 1 | Slot 1 issues this cycle |
| iss1_simd | output | 1 | Slot 1 mode, 1 = SIMD |
| iss1_mask | output | 4 | Slot 1 lane mask |
| iss1_off | output | 26 | Slot 1 local offset |
| iss1_coef | output | 16 | Slot 1 coefficient |
| iss1_data | output | 16 | Slot 1 operand |
| clk_en | output | 1 | Clock enable for the rest of the core |

## Verification
Pairing is tested with every combination of two queued instructions: both modes for each and all four SISD lanes for each. This separates pairs that issue together from pairs that must be split over two cycles. A single SISD instruction is run against all sixteen `lane_busy` patterns to show that only its own lane can block it. Zero operands, zero coefficients and foreign node fields are mixed with one valid packet to show that only the valid one reaches a slot. Further runs fill the queue with conflicting instructions, offer both sources at once and let the block fall idle, which covers backpressure, source order and the one-cycle tail of the clock enable.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 32;
    localparam int NODE_W = 6;
    localparam int OFF_W  = ADDR_W - NODE_W;
    localparam int LANES  = 4;
    localparam int SEL_W  = $clog2(LANES);
    localparam int PKT_W  = 1 + ADDR_W + 2 * DATA_W;

    typedef struct packed {
        logic              simd;
        logic [NODE_W-1:0] node;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] coef;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef struct packed {
        logic              simd;
        logic [LANES-1:0]  mask;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] coef;
        logic [DATA_W-1:0] data;
    } instr_t;
endpackage

// File: rtl/fe_decode.sv
`timescale 1ns/1ps
// Turns a raw packet into a queued instruction and flags work worth keeping.
module fe_decode
    import fe_pkg::*;
#(
    parameter logic [NODE_W-1:0] NODE_ID = 6'd0
) (
    input  pkt_t   pkt,
    output instr_t ins,
    output logic   keep
);
    logic node_hit;
    logic nonzero;

    always_comb begin
        node_hit = (pkt.node == NODE_ID);
        nonzero  = (pkt.data != '0) && (pkt.coef != '0);
        keep     = node_hit && nonzero;

        ins.simd = pkt.simd;
        ins.off  = pkt.off;
        ins.coef = pkt.coef;
        ins.data = pkt.data;
        if (pkt.simd) begin
            ins.mask = '1;
        end else begin
            ins.mask = LANES'(1) << pkt.off[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/fe_fifo.sv
`timescale 1ns/1ps
// Instruction queue: one push and zero, one or two pops per cycle.
module fe_fifo
    import fe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  instr_t           din,
    input  logic [1:0]       pop_cnt,
    output instr_t           head0,
    output instr_t           head1,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        instr_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
    } state_t;

    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    state_t st_d;
    state_t st_q;
    logic [PTR_W-1:0] rd_next;

    always_comb begin
        st_d    = st_q;
        rd_next = st_q.rd + PTR_ONE;
        head0   = st_q.mem[st_q.rd];
        head1   = st_q.mem[rd_next];
        count   = st_q.cnt;

        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = st_q.wr + PTR_ONE;
        end
        st_d.rd  = st_q.rd + PTR_W'(pop_cnt);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fe_dispatch.sv
`timescale 1ns/1ps
// Picks zero, one or two head instructions whose lanes are free and disjoint.
module fe_dispatch
    import fe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  instr_t           head0,
    input  instr_t           head1,
    input  logic [CNT_W-1:0] count,
    input  logic [LANES-1:0] lane_busy,
    output logic             go0,
    output logic             go1,
    output logic [1:0]       pop_cnt
);
    logic [LANES-1:0] claimed;

    always_comb begin
        go0     = (count != '0) && ((head0.mask & lane_busy) == '0);
        claimed = lane_busy | head0.mask;
        go1     = go0 && (count >= CNT_W'(2)) && ((head1.mask & claimed) == '0);
        pop_cnt = {1'b0, go0} + {1'b0, go1};
    end
endmodule

// File: rtl/fe_event_front.sv
`timescale 1ns/1ps
// Event-driven front end: source select, decode, queue, dual issue, clock enable.
module fe_event_front
    import fe_pkg::*;
#(
    parameter logic [NODE_W-1:0] NODE_ID = 6'd5,
    parameter int                DEPTH   = 4,
    localparam int               CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_valid,
    input  logic [PKT_W-1:0]  net_pkt,
    output logic              net_ready,
    input  logic              bus_valid,
    input  logic [PKT_W-1:0]  bus_pkt,
    output logic              bus_ready,
    input  logic [LANES-1:0]  lane_busy,
    output logic              iss0_valid,
    output logic              iss0_simd,
    output logic [LANES-1:0]  iss0_mask,
    output logic [OFF_W-1:0]  iss0_off,
    output logic [DATA_W-1:0] iss0_coef,
    output logic [DATA_W-1:0] iss0_data,
    output logic              iss1_valid,
    output logic              iss1_simd,
    output logic [LANES-1:0]  iss1_mask,
    output logic [OFF_W-1:0]  iss1_off,
    output logic [DATA_W-1:0] iss1_coef,
    output logic [DATA_W-1:0] iss1_data,
    output logic              clk_en
);
    typedef struct packed {
        logic active;
    } state_t;

    state_t st_d;
    state_t st_q;

    pkt_t             sel_pkt;
    instr_t           dec_ins;
    logic             dec_keep;
    logic             fifo_full;
    logic             take;
    logic             push;
    instr_t           head0;
    instr_t           head1;
    logic [CNT_W-1:0] fifo_count;
    logic             go0;
    logic             go1;
    logic [1:0]       pop_cnt;
    logic             active_now;

    fe_decode #(.NODE_ID(NODE_ID)) u_decode (
        .pkt  (sel_pkt),
        .ins  (dec_ins),
        .keep (dec_keep)
    );

    fe_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .din     (dec_ins),
        .pop_cnt (pop_cnt),
        .head0   (head0),
        .head1   (head1),
        .count   (fifo_count)
    );

    fe_dispatch #(.DEPTH(DEPTH)) u_dispatch (
        .head0     (head0),
        .head1     (head1),
        .count     (fifo_count),
        .lane_busy (lane_busy),
        .go0       (go0),
        .go1       (go1),
        .pop_cnt   (pop_cnt)
    );

    always_comb begin
        st_d       = st_q;
        fifo_full  = (fifo_count == CNT_W'(DEPTH));
        net_ready  = !fifo_full;
        bus_ready  = !fifo_full && !net_valid;
        sel_pkt    = net_valid ? pkt_t'(net_pkt) : pkt_t'(bus_pkt);
        take       = (net_valid || bus_valid) && !fifo_full;
        push       = take && dec_keep;

        active_now = (fifo_count != '0) || (lane_busy != '0) || net_valid || bus_valid;
        st_d.active = active_now;
        clk_en     = active_now || st_q.active;

        iss0_valid = go0;
        iss0_simd  = head0.simd;
        iss0_mask  = head0.mask;
        iss0_off   = head0.off;
        iss0_coef  = head0.coef;
        iss0_data  = head0.data;
        iss1_valid = go1;
        iss1_simd  = head1.simd;
        iss1_mask  = head1.mask;
        iss1_off   = head1.off;
        iss1_coef  = head1.coef;
        iss1_data  = head1.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fe_front_chk.sv
`timescale 1ns/1ps
module fe_front_chk
    import fe_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             net_valid,
    input logic             net_ready,
    input logic             bus_ready,
    input logic [LANES-1:0] lane_busy,
    input logic             iss0_valid,
    input logic             iss0_simd,
    input logic [LANES-1:0] iss0_mask,
    input logic             iss1_valid,
    input logic [LANES-1:0] iss1_mask,
    input logic             clk_en,
    input logic [CNT_W-1:0] fifo_count
);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));
    assert_full_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CNT_W'(DEPTH)) |-> (!net_ready && !bus_ready));
    assert_bus_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        net_valid |-> !bus_ready);
    assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> iss0_valid);
    assert_free_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> ((iss0_mask & lane_busy) == '0));
    assert_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> (((iss0_mask | lane_busy) & iss1_mask) == '0));
    assert_simd_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_valid && iss0_simd) |-> (iss0_mask == '1));
    assert_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count != '0) |-> clk_en);
    assert_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(fifo_count == '0));
endmodule

bind fe_event_front fe_front_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .net_valid  (net_valid),
    .net_ready  (net_ready),
    .bus_ready  (bus_ready),
    .lane_busy  (lane_busy),
    .iss0_valid (iss0_valid),
    .iss0_simd  (iss0_simd),
    .iss0_mask  (iss0_mask),
    .iss1_valid (iss1_valid),
    .iss1_mask  (iss1_mask),
    .clk_en     (clk_en),
    .fifo_count (fifo_count)
);

// File: tb/fe_event_front_test.sv
`timescale 1ns/1ps
module fe_event_front_test;
    import fe_pkg::*;

    localparam logic [NODE_W-1:0] NODE = 6'd5;
    localparam logic [OFF_W-1:0]  OFF_BASE = 26'h1555550;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              net_valid = 1'b0;
    logic [PKT_W-1:0]  net_pkt = '0;
    logic              net_ready;
    logic              bus_valid = 1'b0;
    logic [PKT_W-1:0]  bus_pkt = '0;
    logic              bus_ready;
    logic [LANES-1:0]  lane_busy = '0;
    logic              iss0_valid, iss0_simd, iss1_valid, iss1_simd;
    logic [LANES-1:0]  iss0_mask, iss1_mask;
    logic [OFF_W-1:0]  iss0_off, iss1_off;
    logic [DATA_W-1:0] iss0_coef, iss0_data, iss1_coef, iss1_data;
    logic              clk_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fe_event_front #(.NODE_ID(NODE), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .net_valid(net_valid), .net_pkt(net_pkt), .net_ready(net_ready),
        .bus_valid(bus_valid), .bus_pkt(bus_pkt), .bus_ready(bus_ready),
        .lane_busy(lane_busy),
        .iss0_valid(iss0_valid), .iss0_simd(iss0_simd), .iss0_mask(iss0_mask),
        .iss0_off(iss0_off), .iss0_coef(iss0_coef), .iss0_data(iss0_data),
        .iss1_valid(iss1_valid), .iss1_simd(iss1_simd), .iss1_mask(iss1_mask),
        .iss1_off(iss1_off), .iss1_coef(iss1_coef), .iss1_data(iss1_data),
        .clk_en(clk_en)
    );

    function automatic logic [PKT_W-1:0] mk(input logic simd, input logic [NODE_W-1:0] node,
                                            input logic [OFF_W-1:0] off,
                                            input logic [DATA_W-1:0] coef,
                                            input logic [DATA_W-1:0] data);
        return {simd, node, off, coef, data};
    endfunction

    function automatic logic [LANES-1:0] exp_mask(input logic simd, input logic [1:0] lane);
        return simd ? 4'hF : (4'b0001 << lane);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; offers the packet across exactly one rising edge.
    task automatic send_net(input logic [PKT_W-1:0] p);
        net_pkt   = p;
        net_valid = 1'b1;
        @(negedge clk);
        net_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 iss0_valid", iss0_valid, 0);
        chk("R1 iss1_valid", iss1_valid, 0);
        chk("R1 clk_en", clk_en, 0);
        chk("R1 net_ready", net_ready, 1);
        chk("R1 bus_ready", bus_ready, 1);
        @(negedge clk);

        // R7/R8/R10: every pairing of two instructions
        for (int sa = 0; sa < 2; sa++)
        for (int la = 0; la < 4; la++)
        for (int sb = 0; sb < 2; sb++)
        for (int lb = 0; lb < 4; lb++) begin
            logic [LANES-1:0] ma, mb;
            logic [DATA_W-1:0] da, db;
            ma = exp_mask(sa[0], la[1:0]);
            mb = exp_mask(sb[0], lb[1:0]);
            da = DATA_W'(16'h0100 + sa * 16 + la);
            db = DATA_W'(16'h0200 + sb * 16 + lb);
            lane_busy = '1;
            send_net(mk(sa[0], NODE, OFF_BASE | OFF_W'(la), 16'h0007, da));
            send_net(mk(sb[0], NODE, OFF_BASE | OFF_W'(lb), 16'h0009, db));
            lane_busy = '0;
            #1;
            chk("R6 head issues", iss0_valid, 1);
            chk("R8 mask slot0", iss0_mask, ma);
            chk("R10 data slot0", iss0_data, da);
            chk("R10 off slot0", iss0_off, OFF_BASE | OFF_W'(la));
            chk("R7 pair issue", iss1_valid, (ma & mb) == 0);
            if ((ma & mb) == 0) begin
                chk("R8 mask slot1", iss1_mask, mb);
                chk("R10 coef slot1", iss1_coef, 16'h0009);
            end
            @(negedge clk);
            #1;
            if ((ma & mb) != 0) begin
                chk("R7 deferred issue", iss0_valid, 1);
                chk("R7 deferred data", iss0_data, db);
                @(negedge clk);
                #1;
            end
            chk("R6 drained", iss0_valid, 0);
            @(negedge clk);
        end

        // R6: a SISD head blocked only by its own lane
        for (int l = 0; l < 4; l++)
        for (int b = 0; b < 16; b++) begin
            lane_busy = '1;
            send_net(mk(1'b0, NODE, OFF_W'(l), 16'h0003, 16'h0044));
            lane_busy = LANES'(b);
            #1;
            chk("R6 busy gating", iss0_valid, !b[l]);
            lane_busy = '0;
            @(negedge clk);
            @(negedge clk);
        end

        // R2/R3: discarded packets never reach a slot
        lane_busy = '1;
        send_net(mk(1'b0, NODE, 26'd0, 16'h0005, 16'h0000));
        send_net(mk(1'b0, NODE, 26'd1, 16'h0000, 16'h0006));
        send_net(mk(1'b1, NODE + 6'd1, 26'd2, 16'h0005, 16'h0006));
        send_net(mk(1'b0, NODE, 26'd3, 16'h0005, 16'h0ABC));
        lane_busy = '0;
        #1;
        chk("R3 zero dropped head", iss0_data, 16'h0ABC);
        chk("R2 foreign dropped", iss1_valid, 0);
        @(negedge clk);
        #1;
        chk("R3 nothing left", iss0_valid, 0);
        @(negedge clk);

        // R4: full queue stalls and refuses a fifth packet
        begin
            int n;
            n = 0;
            lane_busy = '1;
            for (int k = 1; k <= 4; k++)
                send_net(mk(1'b0, NODE, 26'd0, 16'h0001, DATA_W'(k)));
            #1;
            chk("R4 net_ready full", net_ready, 0);
            chk("R4 bus_ready full", bus_ready, 0);
            send_net(mk(1'b0, NODE, 26'd0, 16'h0001, 16'd99));
            lane_busy = '0;
            for (int c = 0; c < 6; c++) begin
                #1;
                if (iss0_valid) begin
                    n++;
                    chk("R4 order", iss0_data, DATA_W'(n));
                end
                @(negedge clk);
            end
            chk("R4 issued count", n, 4);
            chk("R4 ready back", net_ready, 1);
        end

        // R5: network wins, bus follows
        lane_busy = '1;
        net_pkt   = mk(1'b0, NODE, 26'd0, 16'h0002, 16'h00AA);
        bus_pkt   = mk(1'b0, NODE, 26'd1, 16'h0002, 16'h00BB);
        net_valid = 1'b1;
        bus_valid = 1'b1;
        #1;
        chk("R5 bus held", bus_ready, 0);
        chk("R5 net taken", net_ready, 1);
        @(negedge clk);
        net_valid = 1'b0;
        #1;
        chk("R5 bus ready", bus_ready, 1);
        @(negedge clk);
        bus_valid = 1'b0;
        lane_busy = '0;
        #1;
        chk("R5 net first", iss0_data, 16'h00AA);
        chk("R5 bus second", iss1_data, 16'h00BB);
        chk("R5 pair valid", iss1_valid, 1);
        @(negedge clk);

        // R9: clock enable and its one-cycle tail
        @(negedge clk);
        #1;
        chk("R9 idle off", clk_en, 0);
        @(negedge clk);
        net_pkt   = mk(1'b0, NODE, 26'd0, 16'h0002, 16'h0000);
        net_valid = 1'b1;
        #1;
        chk("R9 wake on packet", clk_en, 1);
        @(negedge clk);
        net_valid = 1'b0;
        #1;
        chk("R9 tail cycle", clk_en, 1);
        @(negedge clk);
        #1;
        chk("R9 off after tail", clk_en, 0);
        lane_busy = 4'b0100;
        #1;
        chk("R9 busy lane wakes", clk_en, 1);
        lane_busy = '0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R9 off again", clk_en, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule